// File: doc/BRIEF.md
# PCI Target Transaction Sequencer

This block is the target-only bus engine of a 32-bit PCI-style local-bus interface. On every rising clock edge it looks at the framing, initiator-ready and IDSEL inputs, and at the multiplexed address/data and command/byte-enable lines. When a memory command hits the block's base-address window, or a configuration command arrives with IDSEL high, it claims the cycle. It then paces each data phase with its target-ready output and finishes with a one-clock drive-high turnaround before it lets go of the bus.

Each bus pin is split into an input, an output value and an output enable. Pads and tri-state buffers sit outside this block. On the user side there is a word address with a counter, a write-data bus, and one-cycle read and write strobes. Memory and configuration accesses each get their own strobe pair and their own read-return bus. A separate configuration block owns the base address and the memory-enable bit and feeds them in.

Top module: `pci_tgt_fsm`

## Requirements
- R1: While reset is low, and afterwards until a transaction is claimed, `ctl_oe_o` and `ad_oe_o` are 0 and all four user strobes are 0.
- R2: Take the address edge to be the rising edge that samples `frame_n_i` going from 1 to 0. When the cycle is claimed, `ctl_oe_o` rises after edge+1 with `devsel_n_o`=1 and `trdy_n_o`=1. `devsel_n_o` falls after edge+2, and `trdy_n_o` falls after edge+3.
- R3: A memory command is `cbe_n_i[3:1]`=3'b011 at the address edge. It is claimed only when `mem_en_i`=1 and the address matches `bar_base_i` in bits [31:BAR_LSB]. Any other command code, an address outside the window, or `mem_en_i`=0 leaves every output enable and strobe at 0.
- R4: A configuration command is `cbe_n_i[3:1]`=3'b101. It is claimed only when `idsel_i`=1 at the address edge, and is ignored otherwise.
- R5: `cbe_n_i[0]` sets the direction: 0 means read and 1 means write. Each transfer raises exactly one strobe. Memory accesses use `mem_rd_o` or `mem_wr_o`, and configuration accesses use `cfg_rd_o` or `cfg_wr_o`. On a write, `wdata_o` equals `ad_i` in that cycle.
- R6: A transfer happens in each clock where `trdy_n_o`=0 and `irdy_n_i`=0. A clock with `irdy_n_i`=1 is a wait and raises no strobe. `xfer_addr_o` starts at the sampled address and advances by 4 after each transfer.
- R7: A transfer with `frame_n_i`=1 is the final one. In the next clock `ctl_oe_o`=1 with `devsel_n_o`, `trdy_n_o` and `stop_n_o` all 1. In the clock after that `ctl_oe_o`=0.
- R8: On reads, `ad_oe_o` is 1 from edge+1 until the final transfer edge. It is never 1 on writes.
- R9: `stop_n_o` is 1 in every clock where `ctl_oe_o` is 1.
- R10: On a read transfer, `ad_o` carries `cfg_rdata_i` for a configuration access and `mem_rdata_i` for a memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_n_i | input | 1 | Cycle framing from the initiator, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| idsel_i | input | 1 | Configuration select |
| ad_i | input | 32 | Address/data bus, input side |
| cbe_n_i | input | 4 | Command in the address phase, byte enables in data phases |
| ad_o | output | 32 | Read data driven onto the bus |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| devsel_n_o | output | 1 | Claim indication, active low |
| trdy_n_o | output | 1 | Target ready, active low |
| stop_n_o | output | 1 | Target stop request, held high |
| ctl_oe_o | output | 1 | Output enable for the three target control lines |
| bar_base_i | input | 32 | Base address from the configuration block |
| mem_en_i | input | 1 | Memory-space response enable |
| xfer_addr_o | output | 32 | Address of the current data phase |
| wdata_o | output | 32 | Write data to the user side |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 32 | Memory read return |
| cfg_rd_o | output | 1 | Configuration read strobe |
| cfg_wr_o | output | 1 | Configuration write strobe |
| cfg_rdata_i | input | 32 | Configuration read return |

## Verification
The two events that can share a cycle are a data transfer and the final-phase detection: one clock both strobes the last word and moves the sequencer into the turnaround. The bench forces this with single-word cycles, where `frame_n_i` rises together with the first `irdy_n_i` assertion, and with bursts whose last word follows initiator wait states. A per-clock model computes the expected strobe, address and data for that cycle. It also expects the drive-high turnaround exactly one clock later and the release one clock after that, and any slip by a cycle is reported as a mismatch.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_CLAIM_HI,
    ST_SEL,
    ST_XFER,
    ST_TURN
  } tgt_st_e;

  typedef struct packed {
    logic hit;
    logic cfg;
    logic wr;
  } claim_t;
endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 4,
  parameter int BAR_LSB = 8
) (
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cmd_i,
  input  logic          idsel_i,
  input  logic [AW-1:0] bar_base_i,
  input  logic          mem_en_i,
  output claim_t        claim_o
);
  localparam logic [AW-1:0] WIN_MASK = ~((AW'(1) << BAR_LSB) - AW'(1));

  logic in_win, is_mem, is_cfg;

  assign in_win = ((addr_i ^ bar_base_i) & WIN_MASK) == '0;
  assign is_mem = (cmd_i[3:1] == 3'b011) && in_win && mem_en_i;
  assign is_cfg = (cmd_i[3:1] == 3'b101) && idsel_i;

  assign claim_o.hit = is_mem || is_cfg;
  assign claim_o.cfg = cmd_i[3];
  assign claim_o.wr  = cmd_i[0];
endmodule

// File: rtl/pci_tgt_seq.sv
module pci_tgt_seq
  import pci_tgt_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    frame_n_i,
  input  logic    irdy_n_i,
  input  logic    hit_i,
  output tgt_st_e st_o,
  output logic    addr_phase_o,
  output logic    xfer_o
);
  tgt_st_e st_q, st_d;
  logic    frame_q;

  assign addr_phase_o = (st_q == ST_IDLE) && frame_q && !frame_n_i;
  assign xfer_o       = (st_q == ST_XFER) && !irdy_n_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (addr_phase_o) st_d = ST_DECODE;
      ST_DECODE:   st_d = hit_i ? ST_CLAIM_HI : ST_IDLE;
      ST_CLAIM_HI: st_d = ST_SEL;
      ST_SEL:      st_d = ST_XFER;
      ST_XFER:     if (xfer_o && frame_n_i) st_d = ST_TURN;
      ST_TURN:     st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      frame_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      frame_q <= frame_n_i;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/pci_tgt_dpath.sv
module pci_tgt_dpath #(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_phase_i,
  input  logic          xfer_i,
  input  logic [AW-1:0] ad_i,
  input  logic [CW-1:0] cbe_i,
  input  logic          idsel_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cmd_o,
  output logic          idsel_o
);
  localparam logic [AW-1:0] STEP = AW'(AW / 8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      cmd_o   <= '0;
      idsel_o <= 1'b0;
    end else if (addr_phase_i) begin
      addr_o  <= ad_i;
      cmd_o   <= cbe_i;
      idsel_o <= idsel_i;
    end else if (xfer_i) begin
      addr_o  <= addr_o + STEP;
    end
  end
endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
  import pci_tgt_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 4,
  parameter int BAR_LSB = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_n_i,
  input  logic          irdy_n_i,
  input  logic          idsel_i,
  input  logic [AW-1:0] ad_i,
  input  logic [CW-1:0] cbe_n_i,
  output logic [AW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          devsel_n_o,
  output logic          trdy_n_o,
  output logic          stop_n_o,
  output logic          ctl_oe_o,
  input  logic [AW-1:0] bar_base_i,
  input  logic          mem_en_i,
  output logic [AW-1:0] xfer_addr_o,
  output logic [AW-1:0] wdata_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          cfg_rd_o,
  output logic          cfg_wr_o,
  input  logic [AW-1:0] cfg_rdata_i
);
  tgt_st_e       st;
  claim_t        claim;
  logic          addr_phase, xfer;
  logic [CW-1:0] cmd_q;
  logic          idsel_q;
  logic          owned;

  pci_tgt_dpath #(.AW(AW), .CW(CW)) dpath_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_phase_i (addr_phase),
    .xfer_i       (xfer),
    .ad_i         (ad_i),
    .cbe_i        (cbe_n_i),
    .idsel_i      (idsel_i),
    .addr_o       (xfer_addr_o),
    .cmd_o        (cmd_q),
    .idsel_o      (idsel_q)
  );

  pci_tgt_decode #(.AW(AW), .CW(CW), .BAR_LSB(BAR_LSB)) decode_i (
    .addr_i     (xfer_addr_o),
    .cmd_i      (cmd_q),
    .idsel_i    (idsel_q),
    .bar_base_i (bar_base_i),
    .mem_en_i   (mem_en_i),
    .claim_o    (claim)
  );

  pci_tgt_seq seq_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_n_i    (frame_n_i),
    .irdy_n_i     (irdy_n_i),
    .hit_i        (claim.hit),
    .st_o         (st),
    .addr_phase_o (addr_phase),
    .xfer_o       (xfer)
  );

  // Read data owns AD from the claim clock through the last data phase
  assign owned      = (st == ST_CLAIM_HI) || (st == ST_SEL) || (st == ST_XFER);
  assign ctl_oe_o   = owned || (st == ST_TURN);
  assign devsel_n_o = !((st == ST_SEL) || (st == ST_XFER));
  assign trdy_n_o   = (st != ST_XFER);
  assign stop_n_o   = 1'b1;
  assign ad_oe_o    = owned && !claim.wr;
  assign ad_o       = claim.cfg ? cfg_rdata_i : mem_rdata_i;
  assign wdata_o    = ad_i;

  assign mem_rd_o = xfer && !claim.cfg && !claim.wr;
  assign mem_wr_o = xfer && !claim.cfg &&  claim.wr;
  assign cfg_rd_o = xfer &&  claim.cfg && !claim.wr;
  assign cfg_wr_o = xfer &&  claim.cfg &&  claim.wr;
endmodule

// File: rtl/pci_tgt_fsm_chk.sv
module pci_tgt_fsm_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irdy_n_i,
  input logic          ctl_oe_o,
  input logic          devsel_n_o,
  input logic          trdy_n_o,
  input logic          stop_n_o,
  input logic          ad_oe_o,
  input logic [AW-1:0] xfer_addr_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic          cfg_rd_o,
  input logic          cfg_wr_o
);
  logic any_strobe;
  assign any_strobe = mem_rd_o || mem_wr_o || cfg_rd_o || cfg_wr_o;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!ctl_oe_o && !ad_oe_o && !any_strobe);
    end
  end

  assert_devsel_after_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(devsel_n_o) |-> $past(ctl_oe_o) && $past(devsel_n_o));

  assert_trdy_after_devsel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trdy_n_o) |-> $past(!devsel_n_o) && $past(ctl_oe_o));

  assert_single_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o, cfg_rd_o, cfg_wr_o}));

  assert_strobe_on_handshake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strobe |-> !trdy_n_o && !irdy_n_i && ctl_oe_o);

  assert_addr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strobe |=> xfer_addr_o == $past(xfer_addr_o) + AW'(4));

  assert_release_after_turn_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctl_oe_o) |-> $past(devsel_n_o) && $past(trdy_n_o) && $past(stop_n_o));

  assert_turn_one_clock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_oe_o && trdy_n_o && $past(!trdy_n_o)) |=> !ctl_oe_o);

  assert_ad_not_on_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> ctl_oe_o && !mem_wr_o && !cfg_wr_o);
endmodule

bind pci_tgt_fsm pci_tgt_fsm_chk #(.AW(AW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irdy_n_i    (irdy_n_i),
  .ctl_oe_o    (ctl_oe_o),
  .devsel_n_o  (devsel_n_o),
  .trdy_n_o    (trdy_n_o),
  .stop_n_o    (stop_n_o),
  .ad_oe_o     (ad_oe_o),
  .xfer_addr_o (xfer_addr_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .cfg_rd_o    (cfg_rd_o),
  .cfg_wr_o    (cfg_wr_o)
);

// File: tb/pci_tgt_fsm_tb_top.sv
module pci_tgt_fsm_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0, mem_en = 1'b1;
  logic [31:0] ad = '0, bar = 32'hCD00_0000;
  logic [3:0]  cbe = '0;
  logic [31:0] ad_o, xfer_addr, wdata, mem_rdata, cfg_rdata;
  logic        ad_oe, devsel_n, trdy_n, stop_n, ctl_oe;
  logic        mem_rd, mem_wr, cfg_rd, cfg_wr;
  int          n_cmp = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  assign mem_rdata = xfer_addr ^ 32'h5A5A_0000;
  assign cfg_rdata = ~xfer_addr;

  pci_tgt_fsm dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .frame_n_i(frame_n), .irdy_n_i(irdy_n),
    .idsel_i(idsel), .ad_i(ad), .cbe_n_i(cbe), .ad_o(ad_o), .ad_oe_o(ad_oe),
    .devsel_n_o(devsel_n), .trdy_n_o(trdy_n), .stop_n_o(stop_n), .ctl_oe_o(ctl_oe),
    .bar_base_i(bar), .mem_en_i(mem_en), .xfer_addr_o(xfer_addr), .wdata_o(wdata),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_rdata_i(mem_rdata),
    .cfg_rd_o(cfg_rd), .cfg_wr_o(cfg_wr), .cfg_rdata_i(cfg_rdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Registered bus-side outputs against expected levels
  task automatic chk_bus(input string req, input bit oe, input bit dev_n, input bit trdy_exp_n, input bit adoe);
    chk(req, "ctl_oe", {31'b0, ctl_oe}, {31'b0, oe});
    chk(req, "ad_oe", {31'b0, ad_oe}, {31'b0, adoe});
    if (oe) begin
      chk(req, "devsel_n", {31'b0, devsel_n}, {31'b0, dev_n});
      chk(req, "trdy_n", {31'b0, trdy_n}, {31'b0, trdy_exp_n});
      chk("R9", "stop_n", {31'b0, stop_n}, 32'd1);
    end
  endtask

  task automatic chk_strobes(input string req, input logic [3:0] exp);
    chk(req, "strobes{mrd,mwr,crd,cwr}", {28'b0, mem_rd, mem_wr, cfg_rd, cfg_wr}, {28'b0, exp});
  endtask

  function automatic logic [31:0] wval(input int i);
    return 32'h1000_0000 + 32'(i * 32'h0101);
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      chk_bus("R1", 1'b0, 1'b1, 1'b1, 1'b0);
      chk_strobes("R1", 4'b0000);
      @(negedge clk);
    end
  endtask

  // Unclaimed cycle: initiator keeps frame low and asserts irdy for several clocks
  task automatic run_miss(input string req, input logic [3:0] cmd, input logic [31:0] addr, input logic sel);
    frame_n = 1'b0; ad = addr; cbe = cmd; idsel = sel; irdy_n = 1'b1;
    @(negedge clk);
    idsel = 1'b0; cbe = 4'h0; irdy_n = 1'b0; ad = wval(7);
    for (int i = 0; i < 5; i++) begin
      chk_bus(req, 1'b0, 1'b1, 1'b1, 1'b0);
      chk_strobes(req, 4'b0000);
      @(negedge clk);
    end
    frame_n = 1'b1; irdy_n = 1'b1; ad = '0;
    @(negedge clk);
    idle(2);
  endtask

  // Claimed cycle; waitmask bit c holds irdy high during clock c
  task automatic run_hit(input string req, input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                         input int nwords, input int waitmask);
    bit rd = !cmd[0];
    bit cf = cmd[3];
    int done = 0;
    int post = 0;
    bit fin = 1'b0;
    bit xf;
    logic [3:0] exp_st;
    logic [31:0] ea;
    frame_n = 1'b0; ad = addr; cbe = cmd; idsel = sel; irdy_n = 1'b1;
    @(negedge clk);
    idsel = 1'b0; cbe = 4'h0;
    for (int c = 1; c < 200; c++) begin
      if (post == 1) chk_bus("R7", 1'b1, 1'b1, 1'b1, 1'b0);
      else if (post == 2) begin
        chk_bus("R7", 1'b0, 1'b1, 1'b1, 1'b0);
        break;
      end
      else if (c == 1) chk_bus("R2", 1'b0, 1'b1, 1'b1, 1'b0);
      else if (c == 2) chk_bus("R2", 1'b1, 1'b1, 1'b1, rd);
      else if (c == 3) chk_bus("R2", 1'b1, 1'b0, 1'b1, rd);
      else chk_bus("R8", 1'b1, 1'b0, 1'b0, rd);
      if (fin) begin
        irdy_n = 1'b1; frame_n = 1'b1; ad = '0;
      end else begin
        if (frame_n) irdy_n = 1'b0;
        else irdy_n = ((waitmask >> c) & 1) != 0;
        if (!irdy_n && done == nwords - 1) frame_n = 1'b1;
        ad = rd ? 32'h0 : wval(done);
      end
      #1;
      xf = !fin && c >= 4 && !irdy_n;
      if (xf) begin
        exp_st = cf ? (rd ? 4'b0010 : 4'b0001) : (rd ? 4'b1000 : 4'b0100);
        chk_strobes("R5", exp_st);
        ea = addr + 32'(4 * done);
        chk("R6", "xfer_addr", xfer_addr, ea);
        if (rd) chk("R10", "ad_o", ad_o, cf ? ~ea : (ea ^ 32'h5A5A_0000));
        else chk("R5", "wdata", wdata, wval(done));
        done++;
        if (frame_n) fin = 1'b1;
      end else begin
        chk_strobes("R6", 4'b0000);
      end
      @(negedge clk);
      if (fin) post++;
    end
    chk("R6", "words moved", 32'(done), 32'(nwords));
    idle(2);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk_bus("R1", 1'b0, 1'b1, 1'b1, 1'b0);
    chk_strobes("R1", 4'b0000);
    rst_ni = 1'b1;
    @(negedge clk);
    idle(2);

    run_hit("R2", 4'b0111, 32'hCD00_0010, 1'b0, 1, 0);          // single memory write
    run_hit("R6", 4'b0110, 32'hCD00_0020, 1'b0, 4, 0);          // memory read burst
    run_hit("R6", 4'b0111, 32'hCD00_0040, 1'b0, 3, 32'h30);     // write burst, waits c=4,5
    run_hit("R8", 4'b0110, 32'hCD00_0080, 1'b0, 2, 32'h20);     // read, wait before last
    run_hit("R4", 4'b1010, 32'h0000_0004, 1'b1, 2, 0);          // configuration read
    run_hit("R4", 4'b1011, 32'h0000_0010, 1'b1, 1, 32'h10);     // configuration write, one wait
    run_miss("R4", 4'b1010, 32'h0000_0004, 1'b0);               // no IDSEL
    run_miss("R3", 4'b0110, 32'h1200_0000, 1'b0);               // outside window
    run_miss("R3", 4'b0110, 32'hCD00_0100, 1'b0);               // just above window
    run_miss("R3", 4'b0010, 32'hCD00_0000, 1'b0);               // other command code
    run_miss("R3", 4'b1100, 32'hCD00_0000, 1'b0);               // 110x not decoded
    mem_en = 1'b0;
    run_miss("R3", 4'b0110, 32'hCD00_0000, 1'b0);               // memory space disabled
    run_hit("R4", 4'b1011, 32'h0000_0004, 1'b1, 1, 0);          // config still claimed
    mem_en = 1'b1;
    run_hit("R3", 4'b0110, 32'hCD00_00FC, 1'b0, 1, 0);          // top word of window
    bar = 32'h4400_0000;
    run_miss("R3", 4'b0111, 32'hCD00_0000, 1'b0);               // old window now misses
    run_hit("R7", 4'b0111, 32'h4400_00F0, 1'b0, 2, 32'h10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule